// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer execution stage of a small processor datapath. Each cycle it may accept one operation: a destination operand, a source operand, a four-bit operation code, a size select (byte or word) and the current carry flag. One clock later it presents the result, a write-back enable for the register that held the destination, and six status flags. Each flag comes with its own update bit, so the flag register only changes the flags that this operation defines.

Arithmetic covers add, add with carry, subtract, subtract with borrow, compare, increment, decrement and negate. The logic group is AND, OR, XOR, NOT and a flags-only AND test. Compare and test produce flags but no write-back. Increment and decrement leave the carry flag alone. The logic operations force carry and overflow to zero and do not define the half-carry flag. NOT changes no flag at all. In byte mode only the low eight bits of each operand take part, and the upper result byte reads zero.

Top module: `alu_core`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes zero on that edge.
- R2: An operation accepted with `in_valid` high shows its outputs after the next rising edge, with `out_valid` high. After a cycle with `in_valid` low, `out_valid`, `wr_en_o`, `flags_o` and `upd_o` are all zero.
- R3: Add (op 0) gives dst + src, and add-with-carry (op 1) gives dst + src + `cf_i`. C is the carry out of the top bit of the selected size. A is the carry out of bit 3. O is signed overflow. All six flags are updated and the result is written.
- R4: Subtract (op 2) gives dst - src, and subtract-with-borrow (op 3) gives dst - src - `cf_i`. C reports a borrow. A reports a borrow out of bit 3. O is signed overflow. All six flags are updated and the result is written.
- R5: Compare (op 4) produces the flags and the result value of subtract, but `wr_en_o` stays low.
- R6: Increment (op 5) and decrement (op 6) add or subtract one. They update S, Z, A, P and O, never update C, and write the result.
- R7: Negate (op 7) gives 0 - dst. All six flags are updated, and C is set exactly when the operand is non-zero.
- R8: NOT (op 8) writes the bitwise complement of dst and updates no flag.
- R9: AND (op 9), OR (op 10) and XOR (op 11) write the bitwise result. They update C and O with the value zero, update S, Z and P, and do not update A.
- R10: Test (op 12) produces the AND flags of R9 with `wr_en_o` low.
- R11: `flags_o` and `upd_o` bit positions are C=0, P=1, A=2, Z=3, S=4, O=5. A flag bit that is not updated reads zero. S is the top bit of the selected size. Z is set when the selected-size result is zero. P is set when the low result byte has an even number of ones, whatever the size.
- R12: With `wide_i` low (byte mode), the operands' upper bytes are ignored, flags come from bit 7, and `res_o[15:8]` is zero. With `wide_i` high, the operation is 16 bits wide.
- R13: Op codes 13 to 15 are undefined. They give a zero result, `wr_en_o` low and `upd_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| cf_i | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Outputs hold a fresh result |
| res_o | output | 16 | Result value |
| wr_en_o | output | 1 | Write the result back |
| flags_o | output | 6 | Flag values |
| upd_o | output | 6 | Per-flag update mask |

## Verification
Every output comes from one register stage, so an operation accepted at a rising edge is visible from that edge until the next one. The bench drives inputs on falling edges and samples exactly one falling edge later, which lands inside that single-cycle window. It then checks the following cycle with `in_valid` low, where write enable and the update mask must already be zero. Carry-preserving, write-suppressing and flag-clearing rules are checked against the update mask and the write enable at that same sample point.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_NEG = 4'd7,
    OP_NOT = 4'd8,
    OP_AND = 4'd9,
    OP_OR  = 4'd10,
    OP_XOR = 4'd11,
    OP_TST = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } lg_sel_e;

  localparam int NFLAG = 6;
  localparam int F_C = 0;
  localparam int F_P = 1;
  localparam int F_A = 2;
  localparam int F_Z = 3;
  localparam int F_S = 4;
  localparam int F_O = 5;

  localparam logic [NFLAG-1:0] UPD_ALL   = 6'b111111;
  localparam logic [NFLAG-1:0] UPD_NOC   = 6'b111110;
  localparam logic [NFLAG-1:0] UPD_LOGIC = 6'b111011;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 16
) (
  input  logic          wide,
  input  logic          sub,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          a_out,
  output logic          o_out
);
  localparam int HW = DW / 2;

  logic [DW:0] wsum;
  logic [HW:0] bsum;
  logic [4:0]  nib;
  logic        sa, sb, sr;

  always_comb begin
    if (sub) begin
      wsum = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
      bsum = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
      nib  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, cin};
    end else begin
      wsum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
      bsum = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
      nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
    end
    sa = wide ? a[DW-1] : a[HW-1];
    sb = wide ? b[DW-1] : b[HW-1];
    sr = wide ? wsum[DW-1] : bsum[HW-1];
    res   = wide ? wsum[DW-1:0] : {{(DW-HW){1'b0}}, bsum[HW-1:0]};
    c_out = wide ? wsum[DW] : bsum[HW];
    a_out = nib[4];
    o_out = (sub ? (sa != sb) : (sa == sb)) && (sr != sa);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DW = 16
) (
  input  logic          wide,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  import alu_pkg::*;
  localparam int HW = DW / 2;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic v;
    always_comb begin
      unique case (lg_sel_e'(sel))
        LG_AND:  v = a[i] & b[i];
        LG_OR:   v = a[i] | b[i];
        LG_XOR:  v = a[i] ^ b[i];
        default: v = ~a[i];
      endcase
    end
    if (i < HW) begin : g_lo
      assign res[i] = v;
    end else begin : g_hi
      assign res[i] = v & wide;
    end
  end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int DW = 16,
  parameter int PB = 8
) (
  input  logic          wide,
  input  logic [DW-1:0] r,
  output logic          s,
  output logic          z,
  output logic          p
);
  localparam int HW = DW / 2;

  assign s = wide ? r[DW-1] : r[HW-1];
  assign z = wide ? (r == '0) : (r[HW-1:0] == '0);
  assign p = ~^r[PB-1:0];
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op_i,
  input  logic          wide_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic          cf_i,
  output logic          out_valid,
  output logic [DW-1:0] res_o,
  output logic          wr_en_o,
  output logic [5:0]    flags_o,
  output logic [5:0]    upd_o
);
  import alu_pkg::*;

  logic          as_sub, as_cin, is_arith, is_logic, wr_d;
  logic [DW-1:0] as_a, as_b, as_res, lg_res, res_d;
  logic          as_c, as_af, as_o;
  logic [1:0]    lg_sel;
  logic [NFLAG-1:0] upd_d, fl_d;
  logic          st_s, st_z, st_p;

  always_comb begin
    as_sub   = 1'b0;
    as_cin   = 1'b0;
    as_a     = dst_i;
    as_b     = src_i;
    is_arith = 1'b0;
    is_logic = 1'b0;
    lg_sel   = LG_AND;
    wr_d     = 1'b0;
    upd_d    = '0;
    case (op_i)
      OP_ADD: begin is_arith = 1'b1; wr_d = 1'b1; upd_d = UPD_ALL; end
      OP_ADC: begin is_arith = 1'b1; as_cin = cf_i; wr_d = 1'b1; upd_d = UPD_ALL; end
      OP_SUB: begin is_arith = 1'b1; as_sub = 1'b1; wr_d = 1'b1; upd_d = UPD_ALL; end
      OP_SBB: begin
        is_arith = 1'b1; as_sub = 1'b1; as_cin = cf_i; wr_d = 1'b1; upd_d = UPD_ALL;
      end
      OP_CMP: begin is_arith = 1'b1; as_sub = 1'b1; upd_d = UPD_ALL; end
      OP_INC: begin
        is_arith = 1'b1; as_b = {{(DW-1){1'b0}}, 1'b1}; wr_d = 1'b1; upd_d = UPD_NOC;
      end
      OP_DEC: begin
        is_arith = 1'b1; as_sub = 1'b1; as_b = {{(DW-1){1'b0}}, 1'b1};
        wr_d = 1'b1; upd_d = UPD_NOC;
      end
      OP_NEG: begin
        is_arith = 1'b1; as_sub = 1'b1; as_a = '0; as_b = dst_i;
        wr_d = 1'b1; upd_d = UPD_ALL;
      end
      OP_NOT: begin is_logic = 1'b1; lg_sel = LG_NOT; wr_d = 1'b1; end
      OP_AND: begin is_logic = 1'b1; lg_sel = LG_AND; wr_d = 1'b1; upd_d = UPD_LOGIC; end
      OP_OR:  begin is_logic = 1'b1; lg_sel = LG_OR;  wr_d = 1'b1; upd_d = UPD_LOGIC; end
      OP_XOR: begin is_logic = 1'b1; lg_sel = LG_XOR; wr_d = 1'b1; upd_d = UPD_LOGIC; end
      OP_TST: begin is_logic = 1'b1; lg_sel = LG_AND; upd_d = UPD_LOGIC; end
      default: ;
    endcase
  end

  alu_addsub #(.DW(DW)) u_addsub (
    .wide (wide_i),
    .sub  (as_sub),
    .a    (as_a),
    .b    (as_b),
    .cin  (as_cin),
    .res  (as_res),
    .c_out(as_c),
    .a_out(as_af),
    .o_out(as_o)
  );

  alu_bitwise #(.DW(DW)) u_bitwise (
    .wide(wide_i),
    .sel (lg_sel),
    .a   (dst_i),
    .b   (src_i),
    .res (lg_res)
  );

  assign res_d = is_arith ? as_res : (is_logic ? lg_res : '0);

  alu_status #(.DW(DW), .PB(8)) u_status (
    .wide(wide_i),
    .r   (res_d),
    .s   (st_s),
    .z   (st_z),
    .p   (st_p)
  );

  always_comb begin
    fl_d      = '0;
    fl_d[F_C] = is_arith & as_c;
    fl_d[F_A] = is_arith & as_af;
    fl_d[F_O] = is_arith & as_o;
    fl_d[F_S] = st_s;
    fl_d[F_Z] = st_z;
    fl_d[F_P] = st_p;
    fl_d      = fl_d & upd_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_o     <= '0;
      wr_en_o   <= 1'b0;
      flags_o   <= '0;
      upd_o     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_o   <= res_d;
        wr_en_o <= wr_d;
        flags_o <= fl_d;
        upd_o   <= upd_d;
      end else begin
        wr_en_o <= 1'b0;
        flags_o <= '0;
        upd_o   <= '0;
      end
    end
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op_i,
  input logic          wide_i,
  input logic          out_valid,
  input logic [DW-1:0] res_o,
  input logic          wr_en_o,
  input logic [5:0]    flags_o,
  input logic [5:0]    upd_o
);
  localparam int HW = DW / 2;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en_o && upd_o == 6'd0));

  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == 4'd4) |=> (!wr_en_o && upd_o == 6'h3F));

  p_incdec_keepc_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_i == 4'd5 || op_i == 4'd6)) |=> (!upd_o[0] && wr_en_o));

  p_not_noflags_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == 4'd8) |=> (upd_o == 6'd0 && wr_en_o));

  p_logic_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i >= 4'd9 && op_i <= 4'd12)
      |=> (upd_o[0] && upd_o[5] && !upd_o[2] && !flags_o[0] && !flags_o[5]));

  p_test_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i == 4'd12) |=> !wr_en_o);

  p_zero_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && upd_o[3]) |-> (flags_o[3] == (res_o == '0)));

  p_parity_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && upd_o[1]) |-> (flags_o[1] == ~^res_o[7:0]));

  p_byte_upper_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_i) |=> (res_o[DW-1:HW] == '0));

  p_undef_r13: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i >= 4'd13) |=> (!wr_en_o && upd_o == 6'd0));
endmodule

bind alu_core alu_core_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_i     (op_i),
  .wide_i   (wide_i),
  .out_valid(out_valid),
  .res_o    (res_o),
  .wr_en_o  (wr_en_o),
  .flags_o  (flags_o),
  .upd_o    (upd_o)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic        wide_i = 1'b0;
  logic [15:0] dst_i = 16'd0;
  logic [15:0] src_i = 16'd0;
  logic        cf_i = 1'b0;
  logic        out_valid, wr_en_o;
  logic [15:0] res_o;
  logic [5:0]  flags_o, upd_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i), .wide_i(wide_i),
    .dst_i(dst_i), .src_i(src_i), .cf_i(cf_i), .out_valid(out_valid),
    .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .upd_o(upd_o)
  );

  // op, wide, cf, dst, src, result, write, flags {O,S,Z,A,P,C}, update mask
  localparam int NV = 18;
  localparam logic [66:0] VEC [NV] = '{
    {4'd0,  1'b1, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 6'h36, 6'h3F},
    {4'd1,  1'b0, 1'b1, 16'h12FF, 16'h0000, 16'h0000, 1'b1, 6'h0F, 6'h3F},
    {4'd2,  1'b1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 6'h17, 6'h3F},
    {4'd3,  1'b0, 1'b1, 16'h0080, 16'h0000, 16'h007F, 1'b1, 6'h24, 6'h3F},
    {4'd4,  1'b1, 1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b0, 6'h0A, 6'h3F},
    {4'd5,  1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 6'h0E, 6'h3E},
    {4'd6,  1'b0, 1'b0, 16'h0080, 16'h0000, 16'h007F, 1'b1, 6'h24, 6'h3E},
    {4'd7,  1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 6'h0A, 6'h3F},
    {4'd7,  1'b1, 1'b0, 16'h8000, 16'h0000, 16'h8000, 1'b1, 6'h33, 6'h3F},
    {4'd7,  1'b0, 1'b0, 16'h0001, 16'h0000, 16'h00FF, 1'b1, 6'h17, 6'h3F},
    {4'd8,  1'b1, 1'b1, 16'h00F0, 16'h0000, 16'hFF0F, 1'b1, 6'h00, 6'h00},
    {4'd9,  1'b1, 1'b0, 16'hF0F0, 16'h8F0F, 16'h8000, 1'b1, 6'h12, 6'h3B},
    {4'd10, 1'b0, 1'b0, 16'hAA03, 16'h0004, 16'h0007, 1'b1, 6'h00, 6'h3B},
    {4'd11, 1'b1, 1'b1, 16'h5555, 16'h5555, 16'h0000, 1'b1, 6'h0A, 6'h3B},
    {4'd12, 1'b1, 1'b0, 16'h00FF, 16'h0F00, 16'h0000, 1'b0, 6'h0A, 6'h3B},
    {4'd13, 1'b1, 1'b1, 16'h1234, 16'h4321, 16'h0000, 1'b0, 6'h00, 6'h00},
    {4'd0,  1'b0, 1'b0, 16'h017F, 16'hFF01, 16'h0080, 1'b1, 6'h34, 6'h3F},
    {4'd0,  1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1, 6'h15, 6'h3F}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:        return "R3";
      4'd2, 4'd3:        return "R4";
      4'd4:              return "R5";
      4'd5, 4'd6:        return "R6";
      4'd7:              return "R7";
      4'd8:              return "R8";
      4'd9, 4'd10, 4'd11: return "R9";
      4'd12:             return "R10";
      default:           return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic w, input logic cf,
                       input logic [15:0] d, input logic [15:0] s);
    @(negedge clk);
    op_i = op; wide_i = w; cf_i = cf; dst_i = d; src_i = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "res", {16'd0, res_o}, 32'd0);
    check("R1", "wr_en", {31'd0, wr_en_o}, 32'd0);
    check("R1", "flags", {26'd0, flags_o}, 32'd0);
    check("R1", "upd", {26'd0, upd_o}, 32'd0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [66:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v[66:63]);
      issue(v[66:63], v[62], v[61], v[60:45], v[44:29]);
      check("R2", "out_valid", {31'd0, out_valid}, 32'd1);
      check(t, "result", {16'd0, res_o}, {16'd0, v[28:13]});
      check(t, "write", {31'd0, wr_en_o}, {31'd0, v[12]});
      check(t, "flags R11", {26'd0, flags_o}, {26'd0, v[11:6]});
      check(t, "update", {26'd0, upd_o}, {26'd0, v[5:0]});
      if (!v[62]) check("R12", "upper byte", {24'd0, res_o[15:8]}, 32'd0);
    end

    // R2: idle cycle after an operation clears write and update, result held
    issue(4'd0, 1'b1, 1'b0, 16'h0100, 16'h0023);
    @(negedge clk);
    check("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
    check("R2", "idle wr_en", {31'd0, wr_en_o}, 32'd0);
    check("R2", "idle upd", {26'd0, upd_o}, 32'd0);
    check("R2", "idle flags", {26'd0, flags_o}, 32'd0);
    check("R2", "held result", {16'd0, res_o}, 32'h0123);

    // R12: byte mode ignores upper operand bytes (same low bytes, different highs)
    issue(4'd2, 1'b0, 1'b0, 16'hFF10, 16'h3305);
    check("R12", "byte sub result", {16'd0, res_o}, 32'h000B);
    check("R12", "byte sub flags", {26'd0, flags_o}, 32'h0004);

    // R6: carry input has no effect on increment result or C
    issue(4'd5, 1'b1, 1'b1, 16'h0010, 16'h0000);
    check("R6", "inc result", {16'd0, res_o}, 32'h0011);
    check("R6", "inc C value", {31'd0, flags_o[0]}, 32'd0);

    // R4: borrow with cf into SBB word
    issue(4'd3, 1'b1, 1'b1, 16'h0005, 16'h0005);
    check("R4", "sbb result", {16'd0, res_o}, 32'hFFFF);
    check("R4", "sbb flags", {26'd0, flags_o}, 32'h17);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    op_i = 4'd0; wide_i = 1'b1; dst_i = 16'h0001; src_i = 16'h0001; in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset res", {16'd0, res_o}, 32'd0);
    check("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "reset wr_en", {31'd0, wr_en_o}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule